// File: doc/BRIEF.md
# Address Line 20 Gate and Warm Reset Emulator

This block watches a simple I/O write bus. It recognises the legacy keyboard-controller commands that software uses to open or close the gate on CPU address bit 20 and to warm-reset the processor. It also handles a separate fast control port. The block keeps a gate-enable state and forces the outgoing address bit 20 low while that gate is closed. Addresses then wrap at the 1 MB boundary. It issues a one-cycle reset pulse toward the CPU.

A two-bit mode input picks which paths the block acts on:
- keyboard controller only: nothing is intercepted.
- command-port emulation.
- fast port only.
- both paths at once.

When the command ports are not emulated, writes to them are passed on as a one-cycle forward strobe for the real keyboard controller.

The gate register and the reset pulse are registered. Each takes effect in the cycle after the clock edge that samples the write. The outgoing address bit is the combinational AND of the CPU's bit 20 and the registered gate.

Top module: `a20_gate_emu`

## Requirements
- R1: After synchronous reset, gate_en and cpu_reset are 0 and no command is pending. A data-port write of 02h straight after reset leaves gate_en at 0.
- R2: With command emulation active (mode bit 0 = 1), a command-port (64h) write of D1h followed by a data-port (60h) write loads the keyboard-path enable from bit 1 of the data byte. 02h or FFh opens the gate; 00h or FDh closes it.
- R3: A data-port write consumes the pending D1h command. A data-port write with nothing pending changes nothing.
- R4: A command-port write that is neither D1h nor a reset pattern cancels a pending D1h command. A reset-pattern write leaves the pending command in place.
- R5: With command emulation active, a command-port write whose data satisfies (data & F1h) == F0h raises cpu_reset for exactly one cycle, in the cycle after the write edge. Examples are FEh and F0h. D1h, FFh, EEh and AAh raise no pulse.
- R6: With the fast port active (mode bit 1 = 1), a write to port 92h loads the fast-path enable from data bit 1. The same write raises a one-cycle cpu_reset when data bit 0 goes from 0 to 1 relative to the last accepted write. A repeated 1 in bit 0 raises no pulse.
- R7: Mode encoding is 0 = keyboard controller only, 1 = command emulation, 2 = fast port only, 3 = both. In modes 0 and 2, writes to 60h/64h have no effect on the block's state and produce a one-cycle kbc_fwd pulse. In modes 1 and 3, they produce no kbc_fwd. In modes 0 and 1, writes to 92h are not stored.
- R8: gate_en is the OR of the keyboard-path enable (counted only when mode bit 0 = 1) and the fast-path enable (counted only when mode bit 1 = 1). A mode change shows on gate_en one cycle later.
- R9: a20_out equals cpu_a20_in AND gate_en without added delay, so a20_out is 0 whenever the gate is closed.
- R10: A single port-92h write of 03h, made when bit 0 was last 0, opens the gate and raises cpu_reset in the same cycle. On the following cycle, cpu_reset is 0 and the gate stays open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_addr | input | ADDR_W | I/O port address |
| io_data | input | 8 | I/O write data |
| mode | input | 2 | Path select: 0 controller only, 1 command emulation, 2 fast port, 3 both |
| cpu_a20_in | input | 1 | CPU address bit 20 |
| a20_out | output | 1 | Gated address bit 20 toward memory |
| gate_en | output | 1 | Registered effective gate enable |
| cpu_reset | output | 1 | One-cycle CPU warm reset pulse |
| kbc_fwd | output | 1 | One-cycle strobe forwarding an unintercepted 60h/64h write |

## Verification
Two functions can land in the same cycle: the gate change and the warm reset pulse. Both come from one fast-port write that sets data bits 1 and 0 together after bit 0 was last written as 0. The bench first clears the fast port with 00h and then writes 03h. At the following sample point, it requires gate_en high and cpu_reset high in the same cycle, then cpu_reset low with the gate still open one cycle later. A second overlap is also exercised: a command-port reset pattern sent while a D1h command is pending. The bench checks that the pulse appears and that the next data write still reaches the gate.

// File: rtl/a20_pkg.sv
package a20_pkg;

  typedef enum logic [1:0] {
    MODE_KBC  = 2'd0,
    MODE_CHIP = 2'd1,
    MODE_FAST = 2'd2,
    MODE_BOTH = 2'd3
  } a20_mode_e;

  localparam int          DATA_W        = 8;
  localparam logic [7:0]  CMD_WRITE_OUT = 8'hD1;
  localparam logic [7:0]  RST_MASK      = 8'hF1;
  localparam logic [7:0]  RST_MATCH     = 8'hF0;
  localparam int          GATE_BIT      = 1;
  localparam int          PULSE_BIT     = 0;

  localparam int          HIT_DATA      = 0;
  localparam int          HIT_CMD       = 1;
  localparam int          HIT_FAST      = 2;
  localparam int          NUM_PORTS     = 3;

  function automatic logic cmd_path_on(input logic [1:0] m);
    return m[0];
  endfunction

  function automatic logic fast_path_on(input logic [1:0] m);
    return m[1];
  endfunction

  function automatic logic is_reset_pattern(input logic [7:0] d);
    return (d & RST_MASK) == RST_MATCH;
  endfunction

endpackage

// File: rtl/a20_port_decode.sv
module a20_port_decode #(
  parameter int ADDR_W = 16,
  parameter int NPORT  = 3,
  parameter logic [NPORT*ADDR_W-1:0] PORT_LIST = '0
) (
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] io_addr,
  output logic [NPORT-1:0]  hit
);

  for (genvar i = 0; i < NPORT; i++) begin : g_match
    assign hit[i] = io_wr && (io_addr == PORT_LIST[i*ADDR_W +: ADDR_W]);
  end

endmodule

// File: rtl/a20_cmd_seq.sv
module a20_cmd_seq
  import a20_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              wr_data,
  input  logic              wr_cmd,
  input  logic [DATA_W-1:0] data,
  output logic              gate_nxt,
  output logic              rst_req
);

  logic armed_q, armed_n;
  logic gate_q;

  always_comb begin
    armed_n  = armed_q;
    gate_nxt = gate_q;
    rst_req  = 1'b0;
    if (en) begin
      if (wr_cmd) begin
        if (data == CMD_WRITE_OUT) begin
          armed_n = 1'b1;
        end else if (is_reset_pattern(data)) begin
          rst_req = 1'b1;
        end else begin
          armed_n = 1'b0;
        end
      end else if (wr_data && armed_q) begin
        gate_nxt = data[GATE_BIT];
        armed_n  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      gate_q  <= 1'b0;
    end else begin
      armed_q <= armed_n;
      gate_q  <= gate_nxt;
    end
  end

endmodule

// File: rtl/a20_fast_port.sv
module a20_fast_port
  import a20_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              wr,
  input  logic [DATA_W-1:0] data,
  output logic              gate_nxt,
  output logic              rst_req
);

  logic gate_q;
  logic pulse_bit_q;
  logic accept;

  assign accept   = en && wr;
  assign gate_nxt = accept ? data[GATE_BIT] : gate_q;
  assign rst_req  = accept && data[PULSE_BIT] && !pulse_bit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q      <= 1'b0;
      pulse_bit_q <= 1'b0;
    end else if (accept) begin
      gate_q      <= data[GATE_BIT];
      pulse_bit_q <= data[PULSE_BIT];
    end
  end

endmodule

// File: rtl/a20_gate_emu.sv
module a20_gate_emu
  import a20_pkg::*;
#(
  parameter int               ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] PORT_DATA = 16'h0060,
  parameter logic [ADDR_W-1:0] PORT_CMD  = 16'h0064,
  parameter logic [ADDR_W-1:0] PORT_FAST = 16'h0092
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_data,
  input  logic [1:0]        mode,
  input  logic              cpu_a20_in,
  output logic              a20_out,
  output logic              gate_en,
  output logic              cpu_reset,
  output logic              kbc_fwd
);

  localparam logic [NUM_PORTS*ADDR_W-1:0] PORTS = {PORT_FAST, PORT_CMD, PORT_DATA};

  logic [NUM_PORTS-1:0] hit;
  logic cmd_on, fast_on;
  logic kbc_gate_nxt, kbc_rst_req;
  logic fp_gate_nxt, fp_rst_req;
  logic gate_q, rst_q, fwd_q;

  assign cmd_on  = cmd_path_on(mode);
  assign fast_on = fast_path_on(mode);

  a20_port_decode #(
    .ADDR_W   (ADDR_W),
    .NPORT    (NUM_PORTS),
    .PORT_LIST(PORTS)
  ) u_decode (
    .io_wr  (io_wr),
    .io_addr(io_addr),
    .hit    (hit)
  );

  a20_cmd_seq u_cmd (
    .clk     (clk),
    .rst     (rst),
    .en      (cmd_on),
    .wr_data (hit[HIT_DATA]),
    .wr_cmd  (hit[HIT_CMD]),
    .data    (io_data),
    .gate_nxt(kbc_gate_nxt),
    .rst_req (kbc_rst_req)
  );

  a20_fast_port u_fast (
    .clk     (clk),
    .rst     (rst),
    .en      (fast_on),
    .wr      (hit[HIT_FAST]),
    .data    (io_data),
    .gate_nxt(fp_gate_nxt),
    .rst_req (fp_rst_req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= 1'b0;
      rst_q  <= 1'b0;
      fwd_q  <= 1'b0;
    end else begin
      gate_q <= (kbc_gate_nxt && cmd_on) || (fp_gate_nxt && fast_on);
      rst_q  <= kbc_rst_req || fp_rst_req;
      fwd_q  <= (hit[HIT_DATA] || hit[HIT_CMD]) && !cmd_on;
    end
  end

  assign gate_en   = gate_q;
  assign cpu_reset = rst_q;
  assign kbc_fwd   = fwd_q;
  assign a20_out   = cpu_a20_in & gate_q;

endmodule

// File: rtl/a20_gate_emu_chk.sv
module a20_gate_emu_chk #(
  parameter int               ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] PORT_DATA = 16'h0060,
  parameter logic [ADDR_W-1:0] PORT_CMD  = 16'h0064,
  parameter logic [ADDR_W-1:0] PORT_FAST = 16'h0092
) (
  input logic              clk,
  input logic              rst,
  input logic              io_wr,
  input logic [ADDR_W-1:0] io_addr,
  input logic [7:0]        io_data,
  input logic [1:0]        mode,
  input logic              cpu_a20_in,
  input logic              a20_out,
  input logic              gate_en,
  input logic              cpu_reset,
  input logic              kbc_fwd
);

  // R1: reset clears gate and pulse
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!gate_en && !cpu_reset && !kbc_fwd));

  // R5: reset pattern on the command port yields a pulse
  a_r5_pattern_pulses: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(io_wr) && $past(io_addr) == PORT_CMD && $past(mode[0])
     && (($past(io_data) & 8'hF1) == 8'hF0)) |-> cpu_reset);

  // R5/R6: a pulse needs a write to a reset-capable port one cycle before
  a_r6_pulse_source: assert property (@(posedge clk) disable iff (rst)
    cpu_reset |-> ($past(io_wr) && ($past(io_addr) == PORT_CMD || $past(io_addr) == PORT_FAST)));

  // R7: forwarding only in modes without command emulation
  a_r7_fwd_only_unemulated: assert property (@(posedge clk) disable iff (rst)
    kbc_fwd |-> (!$past(mode[0]) && $past(io_wr)));

  // R8: controller-only mode keeps the gate closed
  a_r8_mode0_closed: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0) |=> !gate_en);

  // R8: gate moves only after a write or a mode change
  a_r8_gate_stable: assert property (@(posedge clk) disable iff (rst)
    (!$past(io_wr) && $past(mode) == $past(mode, 2)) |-> $stable(gate_en));

  // R9: closed gate forces the address bit low
  a_r9_wrap_low: assert property (@(posedge clk) disable iff (rst)
    !gate_en |-> !a20_out);

endmodule

bind a20_gate_emu a20_gate_emu_chk #(
  .ADDR_W   (ADDR_W),
  .PORT_DATA(PORT_DATA),
  .PORT_CMD (PORT_CMD),
  .PORT_FAST(PORT_FAST)
) u_chk (.*);

// File: tb/a20_gate_emu_test.sv
module a20_gate_emu_test;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 16;
  localparam logic [15:0] P_DATA = 16'h0060;
  localparam logic [15:0] P_CMD  = 16'h0064;
  localparam logic [15:0] P_FAST = 16'h0092;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              io_wr = 1'b0;
  logic [ADDR_W-1:0] io_addr = '0;
  logic [7:0]        io_data = '0;
  logic [1:0]        mode = 2'd1;
  logic              cpu_a20_in = 1'b1;
  logic              a20_out, gate_en, cpu_reset, kbc_fwd;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  a20_gate_emu uut (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_addr(io_addr), .io_data(io_data),
    .mode(mode), .cpu_a20_in(cpu_a20_in), .a20_out(a20_out), .gate_en(gate_en),
    .cpu_reset(cpu_reset), .kbc_fwd(kbc_fwd)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    io_wr = 1'b1; io_addr = a; io_data = d;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic set_mode(input logic [1:0] m);
    mode = m;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1", "gate after reset", gate_en, 1'b0);
    chk("R1", "pulse after reset", cpu_reset, 1'b0);
    chk("R1", "a20 after reset", a20_out, 1'b0);
    wr(P_DATA, 8'h02);
    chk("R1", "no pending command after reset", gate_en, 1'b0);
  endtask

  task automatic t_cmd_seq();
    wr(P_CMD, 8'hD1);
    chk("R2", "D1 alone keeps gate", gate_en, 1'b0);
    wr(P_DATA, 8'h02);
    chk("R2", "02h opens gate", gate_en, 1'b1);
    chk("R9", "a20 passes when open", a20_out, 1'b1);
    wr(P_DATA, 8'h00);
    chk("R3", "unarmed data write ignored", gate_en, 1'b1);
    wr(P_CMD, 8'hD1); wr(P_DATA, 8'hFD);
    chk("R2", "FDh closes gate", gate_en, 1'b0);
    wr(P_CMD, 8'hD1); wr(P_DATA, 8'hFF);
    chk("R2", "FFh opens gate", gate_en, 1'b1);
  endtask

  task automatic t_disarm();
    wr(P_CMD, 8'hD1); wr(P_CMD, 8'hAA);
    chk("R5", "AAh no pulse", cpu_reset, 1'b0);
    wr(P_DATA, 8'h00);
    chk("R4", "other command cancels D1", gate_en, 1'b1);
    wr(P_CMD, 8'hD1); wr(P_CMD, 8'hFE);
    chk("R5", "FEh pulses while armed", cpu_reset, 1'b1);
    wr(P_DATA, 8'h00);
    chk("R4", "reset pattern keeps D1 pending", gate_en, 1'b0);
  endtask

  task automatic t_pattern();
    wr(P_CMD, 8'hF0);
    chk("R5", "F0h pulse", cpu_reset, 1'b1);
    chk("R7", "no forward when emulated", kbc_fwd, 1'b0);
    idle();
    chk("R5", "pulse lasts one cycle", cpu_reset, 1'b0);
    wr(P_CMD, 8'hFF);
    chk("R5", "FFh no pulse", cpu_reset, 1'b0);
    wr(P_CMD, 8'hEE);
    chk("R5", "EEh no pulse", cpu_reset, 1'b0);
    wr(P_CMD, 8'hD1);
    chk("R5", "D1h no pulse", cpu_reset, 1'b0);
    wr(P_CMD, 8'hAA);
  endtask

  task automatic t_fast();
    set_mode(2'd2);
    chk("R8", "fast mode starts closed", gate_en, 1'b0);
    wr(P_FAST, 8'h02);
    chk("R6", "92h bit1 opens gate", gate_en, 1'b1);
    chk("R6", "bit0 zero no pulse", cpu_reset, 1'b0);
    wr(P_FAST, 8'h03);
    chk("R6", "bit0 rise pulses", cpu_reset, 1'b1);
    wr(P_FAST, 8'h03);
    chk("R6", "bit0 held no pulse", cpu_reset, 1'b0);
    wr(P_FAST, 8'h00);
    chk("R6", "92h bit1 closes gate", gate_en, 1'b0);
    wr(P_CMD, 8'hFE);
    chk("R7", "mode 2 ignores reset pattern", cpu_reset, 1'b0);
    chk("R7", "mode 2 forwards 64h", kbc_fwd, 1'b1);
    idle();
    chk("R7", "forward lasts one cycle", kbc_fwd, 1'b0);
  endtask

  task automatic t_forward();
    set_mode(2'd0);
    wr(P_CMD, 8'hD1);
    chk("R7", "mode 0 forwards 64h", kbc_fwd, 1'b1);
    set_mode(2'd1);
    wr(P_DATA, 8'h02);
    chk("R7", "mode 0 D1 not taken", gate_en, 1'b0);
    wr(P_FAST, 8'h02);
    chk("R7", "mode 1 ignores 92h", gate_en, 1'b0);
    set_mode(2'd2);
    chk("R7", "92h write in mode 1 not stored", gate_en, 1'b0);
  endtask

  task automatic t_merge();
    set_mode(2'd1);
    wr(P_CMD, 8'hD1); wr(P_DATA, 8'h02);
    chk("R8", "keyboard path open", gate_en, 1'b1);
    set_mode(2'd3);
    chk("R8", "both mode uses keyboard path", gate_en, 1'b1);
    set_mode(2'd2);
    chk("R8", "fast mode drops keyboard path", gate_en, 1'b0);
    wr(P_FAST, 8'h02);
    set_mode(2'd1);
    chk("R8", "mode 1 drops fast path", gate_en, 1'b1);
    wr(P_CMD, 8'hD1); wr(P_DATA, 8'h00);
    chk("R8", "keyboard path closed", gate_en, 1'b0);
    set_mode(2'd3);
    chk("R8", "both mode ORs fast path", gate_en, 1'b1);
    cpu_a20_in = 1'b0; #1;
    chk("R9", "a20 follows cpu low", a20_out, 1'b0);
    cpu_a20_in = 1'b1; #1;
    chk("R9", "a20 follows cpu high", a20_out, 1'b1);
    set_mode(2'd0);
    chk("R8", "mode 0 closes gate", gate_en, 1'b0);
    chk("R9", "wrap when closed", a20_out, 1'b0);
  endtask

  task automatic t_same_cycle();
    set_mode(2'd3);
    wr(P_FAST, 8'h00);
    chk("R10", "cleared before overlap", gate_en, 1'b0);
    wr(P_FAST, 8'h03);
    chk("R10", "gate opens with pulse", gate_en, 1'b1);
    chk("R10", "pulse with gate open", cpu_reset, 1'b1);
    idle();
    chk("R10", "pulse ends", cpu_reset, 1'b0);
    chk("R10", "gate stays open", gate_en, 1'b1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_cmd_seq();
    t_disarm();
    t_pattern();
    t_fast();
    t_forward();
    t_merge();
    t_same_cycle();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule